// File: doc/BRIEF.md
# Clock generator mode controller

This block is the synchronous control plane for a differential clock source. It reads two active-low inputs, one for power-down and one for halting the outputs, plus three operating-mode bits and three multiplier bits. From these it derives the power state and the output-stage controls. The output-stage controls are a source select, an enable and a drive-to-ground. It also produces the feedback and prescaler divider values for an external PLL, and it reports settle status.

The settle status comes from down-counters whose lengths are parameters, so one instance can model the real time budgets at the chosen clock rate. Those budgets cover power-up, a multiplier change and the two phases of leaving the halted state.

The PLL, the phase aligner and the analog drivers sit outside. They consume `out_sel`, `out_en`, `out_gnd`, `fb_div` and `pre_div`. System logic watches `settled`, `glitch_free` and `phase_locked` before relying on the clock.

Top module: `ckgen_mode_ctrl`

## Requirements
- R1: `pwr_state` is 0 (down) when `pd_n` was low at the last clock edge. It is 1 (halted) when `pd_n` was high and `halt_n` low. It is 2 (running) when both were high. The new state shows one cycle after the sampling edge.
- R2: In the down state `out_gnd` is 1 and `out_en` is 0. `src_on` stays 1 for PDN_CYC cycles after entering the down state and is then 0. In any other state `src_on` is 1.
- R3: In the halted state `out_en` and `out_gnd` are both 0, which leaves the outputs high-impedance.
- R4: `mode_sel` is captured only at edges where `pd_n` is low. Changes while `pd_n` is high have no effect on `out_sel` or `out_en`. `mode_sel[2]` is the first mode bit and `mode_sel[0]` the last.
- R5: Captured mode 3'b000 gives `out_sel`=0 (phase-aligned clock). Mode 3'b100 gives 1 (raw PLL clock). Mode 3'b110 gives 2 (reference passed through). These three modes enable the outputs in the running state. Modes 3'b010 and 3'b011 (output test) give `out_sel`=0 with `out_en`=0.
- R6: `mult_sel`, registered each cycle, maps to feedback/prescaler values as follows: 0→4/1, 1→9/2, 2→6/1, 4→8/3, 5→16/3, 6→8/1. For these codes `mult_ok` is 1.
- R7: Codes 3 and 7 give `fb_div`=0, `pre_div`=0 and `mult_ok`=0. They also force `out_en` to 0. Modes 3'b001, 3'b101 and 3'b111 also force `out_en` to 0.
- R8: Leaving the down state restarts a PWRUP_CYC timer. `settled` is 1 only outside the down state with that timer expired.
- R9: A change of `mult_sel` sampled outside the down state restarts the settle timer with MULT_CYC. This clears `settled` in the next cycle.
- R10: On a halted-to-running transition, `glitch_free` is 0 for GLITCH_CYC cycles after the new state appears. `phase_locked` is 0 for PHASE_CYC cycles. Both flags are 0 outside the running state.
- R11: During reset the state is down, the captured mode and multiplier are 0, all timers are expired and `src_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Active-low power-down request |
| halt_n | input | 1 | Active-low output halt request |
| mode_sel | input | 3 | Operating-mode bits, first bit in [2] |
| mult_sel | input | 3 | Multiplier code |
| pwr_state | output | 2 | 0 down, 1 halted, 2 running |
| src_on | output | 1 | Clock source powered |
| out_en | output | 1 | Output drivers pass a clock |
| out_gnd | output | 1 | Output drivers pulled to ground |
| out_sel | output | 2 | Output source: 0 aligned, 1 PLL, 2 reference |
| fb_div | output | 5 | PLL feedback divider |
| pre_div | output | 2 | PLL prescaler divider |
| mult_ok | output | 1 | Multiplier code is defined |
| settled | output | 1 | Power-up / multiplier settle complete |
| glitch_free | output | 1 | Edges clean after leaving halt |
| phase_locked | output | 1 | Phase settled after leaving halt |

## Verification
State, enables, source select and divider values all come from registers loaded at the edge that samples the inputs. They are therefore due one cycle after that edge. The timer flags rise exactly the load value in cycles after the loading edge's result appears.

The bench drives inputs at falling edges and steps a behavioural model at each rising edge. It then compares every output at the following falling edge, so each expectation lands in the cycle its count of registers predicts. The scenarios include halt windows that are interrupted and re-entered, mode changes attempted while powered, and undefined multiplier codes.

// File: rtl/ckgen_pkg.sv
// Shared types and the multiplier lookup for the clock generator controller.
// Assumes the divider field widths fit the largest defined ratio.
package ckgen_pkg;

    localparam int FB_W  = 5;
    localparam int PRE_W = 2;

    typedef enum logic [1:0] {
        PS_DOWN = 2'd0,
        PS_HALT = 2'd1,
        PS_RUN  = 2'd2
    } pwr_state_t;

    typedef enum logic [1:0] {
        SRC_ALIGNED = 2'd0,
        SRC_PLL     = 2'd1,
        SRC_REF     = 2'd2
    } out_src_t;

    typedef struct packed {
        logic [FB_W-1:0]  fb;
        logic [PRE_W-1:0] pre;
        logic             ok;
    } mult_cfg_t;

    // Map a multiplier code onto feedback/prescaler values; undefined codes give zeros.
    function automatic mult_cfg_t mult_lookup(input logic [2:0] code);
        mult_cfg_t r;
        r = '0;
        case (code)
            3'd0: r = '{fb: 5'd4,  pre: 2'd1, ok: 1'b1};
            3'd1: r = '{fb: 5'd9,  pre: 2'd2, ok: 1'b1};
            3'd2: r = '{fb: 5'd6,  pre: 2'd1, ok: 1'b1};
            3'd4: r = '{fb: 5'd8,  pre: 2'd3, ok: 1'b1};
            3'd5: r = '{fb: 5'd16, pre: 2'd3, ok: 1'b1};
            3'd6: r = '{fb: 5'd8,  pre: 2'd1, ok: 1'b1};
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ckgen_dn_timer.sv
// Loadable down-counter that reports when it has run out.
// Assumes load_val fits in W bits; load wins over counting.
module ckgen_dn_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Reload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/ckgen_pwr_fsm.sv
// Power-state register: down / halted / running from the two active-low requests.
// Assumes pd_n and halt_n are already synchronous to clk.
module ckgen_pwr_fsm
    import ckgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_n,
    input  logic       halt_n,
    output pwr_state_t state,
    output logic       up_evt,
    output logic       down_evt,
    output logic       resume_evt
);

    pwr_state_t nxt;

    // Power-down has priority over halt.
    always_comb begin
        if (!pd_n)        nxt = PS_DOWN;
        else if (!halt_n) nxt = PS_HALT;
        else              nxt = PS_RUN;
    end

    // State register, reset into the down state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_DOWN;
        else        state <= nxt;
    end

    assign up_evt     = (state == PS_DOWN) && (nxt != PS_DOWN);
    assign down_evt   = (state != PS_DOWN) && (nxt == PS_DOWN);
    assign resume_evt = (state == PS_HALT) && (nxt == PS_RUN);

endmodule

// File: rtl/ckgen_cfg_latch.sv
// Captures operating mode (only while power-down is requested) and the multiplier code.
// Flags a multiplier change seen while the source is powered.
module ckgen_cfg_latch
    import ckgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_n,
    input  logic       powered,
    input  logic [2:0] mode_sel,
    input  logic [2:0] mult_sel,
    output logic [2:0] mode_q,
    output mult_cfg_t  mcfg,
    output logic       mult_chg
);

    logic [2:0] mult_q;

    // Mode bits are only legal to change during power-down, so only sample then.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= 3'b000;
        else if (!pd_n) mode_q <= mode_sel;
    end

    // Multiplier bits may be swapped at any time; register every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) mult_q <= 3'b000;
        else        mult_q <= mult_sel;
    end

    assign mult_chg = powered && (mult_sel != mult_q);
    assign mcfg     = mult_lookup(mult_q);

endmodule

// File: rtl/ckgen_mode_ctrl.sv
// Clock generator mode controller top: power states, output-stage controls,
// PLL divider values and settle timing. Timer lengths are in clk cycles.
// Assumes GLITCH_CYC <= PHASE_CYC and all timer lengths are at least 1.
module ckgen_mode_ctrl
    import ckgen_pkg::*;
#(
    parameter int PWRUP_CYC  = 64,
    parameter int MULT_CYC   = 24,
    parameter int PDN_CYC    = 10,
    parameter int GLITCH_CYC = 3,
    parameter int PHASE_CYC  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             halt_n,
    input  logic [2:0]       mode_sel,
    input  logic [2:0]       mult_sel,
    output logic [1:0]       pwr_state,
    output logic             src_on,
    output logic             out_en,
    output logic             out_gnd,
    output logic [1:0]       out_sel,
    output logic [FB_W-1:0]  fb_div,
    output logic [PRE_W-1:0] pre_div,
    output logic             mult_ok,
    output logic             settled,
    output logic             glitch_free,
    output logic             phase_locked
);

    localparam int MAX_A  = (PWRUP_CYC > MULT_CYC) ? PWRUP_CYC : MULT_CYC;
    localparam int MAX_B  = (PDN_CYC > PHASE_CYC) ? PDN_CYC : PHASE_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T  = (MAX_C > GLITCH_CYC) ? MAX_C : GLITCH_CYC;
    localparam int CW     = $clog2(MAX_T + 1);

    pwr_state_t state;
    logic       up_evt, down_evt, resume_evt;
    logic [2:0] mode_q;
    mult_cfg_t  mcfg;
    logic       mult_chg;
    logic       settle_exp, pdn_exp, glitch_exp, phase_exp;
    logic       clk_mode;
    out_src_t   src;

    ckgen_pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_n       (pd_n),
        .halt_n     (halt_n),
        .state      (state),
        .up_evt     (up_evt),
        .down_evt   (down_evt),
        .resume_evt (resume_evt)
    );

    ckgen_cfg_latch u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_n     (pd_n),
        .powered  (state != PS_DOWN),
        .mode_sel (mode_sel),
        .mult_sel (mult_sel),
        .mode_q   (mode_q),
        .mcfg     (mcfg),
        .mult_chg (mult_chg)
    );

    // Power-up has priority over a multiplier swap on the same edge.
    ckgen_dn_timer #(.W(CW)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (up_evt | mult_chg),
        .load_val (up_evt ? CW'(PWRUP_CYC) : CW'(MULT_CYC)),
        .expired  (settle_exp)
    );

    ckgen_dn_timer #(.W(CW)) u_pdn (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (down_evt),
        .load_val (CW'(PDN_CYC)),
        .expired  (pdn_exp)
    );

    // The two halt-exit windows share structure and differ only in length.
    for (genvar gi = 0; gi < 2; gi++) begin : g_resume
        localparam int LEN = (gi == 0) ? GLITCH_CYC : PHASE_CYC;
        logic exp_w;
        ckgen_dn_timer #(.W(CW)) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (resume_evt),
            .load_val (CW'(LEN)),
            .expired  (exp_w)
        );
        if (gi == 0) begin : g_gl
            assign glitch_exp = exp_w;
        end else begin : g_ph
            assign phase_exp = exp_w;
        end
    end

    // Decode captured mode into an output source and whether it carries a clock.
    always_comb begin
        clk_mode = 1'b0;
        src      = SRC_ALIGNED;
        case (mode_q)
            3'b000: begin clk_mode = 1'b1; src = SRC_ALIGNED; end
            3'b100: begin clk_mode = 1'b1; src = SRC_PLL;     end
            3'b110: begin clk_mode = 1'b1; src = SRC_REF;     end
            default: begin clk_mode = 1'b0; src = SRC_ALIGNED; end
        endcase
    end

    // Output-stage controls from the power state and configuration.
    always_comb begin
        out_gnd = (state == PS_DOWN);
        out_en  = (state == PS_RUN) && clk_mode && mcfg.ok;
    end

    assign pwr_state    = state;
    assign out_sel      = src;
    assign fb_div       = mcfg.fb;
    assign pre_div      = mcfg.pre;
    assign mult_ok      = mcfg.ok;
    assign src_on       = (state != PS_DOWN) || !pdn_exp;
    assign settled      = (state != PS_DOWN) && settle_exp;
    assign glitch_free  = (state == PS_RUN) && glitch_exp;
    assign phase_locked = (state == PS_RUN) && phase_exp;

endmodule

// File: rtl/ckgen_mode_ctrl_chk.sv
// Port-level temporal checks for the clock generator controller, bound to the top.
module ckgen_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_n,
    input logic       halt_n,
    input logic [2:0] mult_sel,
    input logic [1:0] pwr_state,
    input logic       src_on,
    input logic       out_en,
    input logic       out_gnd,
    input logic [1:0] out_sel,
    input logic [4:0] fb_div,
    input logic       settled,
    input logic       glitch_free,
    input logic       phase_locked
);

    assert_enter_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (pwr_state == 2'd0));

    assert_enter_halt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !halt_n) |=> (pwr_state == 2'd1));

    assert_down_grounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (out_gnd && !out_en));

    assert_powered_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pd_n |=> src_on);

    assert_halt_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !halt_n) |=> (!out_en && !out_gnd));

    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_n |=> $stable(out_sel));

    assert_undef_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_div == 5'd0) |-> !out_en);

    assert_pwrup_unsettled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && pd_n) |=> !settled);

    assert_mult_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0 && pd_n && mult_sel != $past(mult_sel)) |=> !settled);

    assert_resume_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1 && pd_n && halt_n) |=> (!glitch_free && !phase_locked));

    assert_phase_after_edges_R10: assert property (@(posedge clk) disable iff (!rst_n)
        phase_locked |-> glitch_free);

endmodule

bind ckgen_mode_ctrl ckgen_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_n         (pd_n),
    .halt_n       (halt_n),
    .mult_sel     (mult_sel),
    .pwr_state    (pwr_state),
    .src_on       (src_on),
    .out_en       (out_en),
    .out_gnd      (out_gnd),
    .out_sel      (out_sel),
    .fb_div       (fb_div),
    .settled      (settled),
    .glitch_free  (glitch_free),
    .phase_locked (phase_locked)
);

// File: tb/tb_ckgen_mode_ctrl.sv
// Behavioural reference bench: the model is stepped at each rising edge and all
// outputs are compared at the following falling edge.
module tb_ckgen_mode_ctrl;

    localparam int PWRUP  = 64;
    localparam int MULTC  = 24;
    localparam int PDN    = 10;
    localparam int GLITCH = 3;
    localparam int PHASE  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_n = 1'b0;
    logic       halt_n = 1'b1;
    logic [2:0] mode_sel = 3'b000;
    logic [2:0] mult_sel = 3'b000;
    logic [1:0] pwr_state;
    logic       src_on, out_en, out_gnd, mult_ok, settled, glitch_free, phase_locked;
    logic [1:0] out_sel;
    logic [4:0] fb_div;
    logic [1:0] pre_div;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // model variables
    int m_st = 0, m_mode = 0, m_mult = 0, m_set = 0, m_pdn = 0, m_gl = 0, m_ph = 0;

    always #2 clk = ~clk;

    ckgen_mode_ctrl #(
        .PWRUP_CYC(PWRUP), .MULT_CYC(MULTC), .PDN_CYC(PDN),
        .GLITCH_CYC(GLITCH), .PHASE_CYC(PHASE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .halt_n(halt_n),
        .mode_sel(mode_sel), .mult_sel(mult_sel), .pwr_state(pwr_state),
        .src_on(src_on), .out_en(out_en), .out_gnd(out_gnd), .out_sel(out_sel),
        .fb_div(fb_div), .pre_div(pre_div), .mult_ok(mult_ok), .settled(settled),
        .glitch_free(glitch_free), .phase_locked(phase_locked)
    );

    task automatic chk(input string req, input string nm, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, nm, act, exp, $time);
        end
    endtask

    function automatic int fb_of(input int c);
        case (c)
            0: return 4;  1: return 9;  2: return 6;
            4: return 8;  5: return 16; 6: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int pre_of(input int c);
        case (c)
            0: return 1; 1: return 2; 2: return 1;
            4: return 3; 5: return 3; 6: return 1;
            default: return 0;
        endcase
    endfunction

    // Advance the model by one rising edge using the inputs held during the cycle.
    task automatic model_edge();
        int nx;
        if (!rst_n) begin
            m_st = 0; m_mode = 0; m_mult = 0; m_set = 0; m_pdn = 0; m_gl = 0; m_ph = 0;
            return;
        end
        nx = !pd_n ? 0 : (!halt_n ? 1 : 2);
        if (m_st != 0 && nx == 0) m_pdn = PDN;
        else if (m_pdn > 0) m_pdn--;
        if (m_st == 0 && nx != 0) m_set = PWRUP;
        else if (m_st != 0 && int'(mult_sel) != m_mult) m_set = MULTC;
        else if (m_set > 0) m_set--;
        if (m_st == 1 && nx == 2) begin m_gl = GLITCH; m_ph = PHASE; end
        else begin
            if (m_gl > 0) m_gl--;
            if (m_ph > 0) m_ph--;
        end
        if (!pd_n) m_mode = int'(mode_sel);
        m_mult = int'(mult_sel);
        m_st = nx;
    endtask

    task automatic compare();
        int ok_m, clkm, sel, en;
        ok_m = (fb_of(m_mult) != 0) ? 1 : 0;
        clkm = (m_mode == 0 || m_mode == 4 || m_mode == 6) ? 1 : 0;
        sel  = (m_mode == 4) ? 1 : ((m_mode == 6) ? 2 : 0);
        en   = (m_st == 2 && clkm == 1 && ok_m == 1) ? 1 : 0;
        chk("R1", "pwr_state", int'(pwr_state), m_st);
        chk("R2", "out_gnd", int'(out_gnd), (m_st == 0) ? 1 : 0);
        chk("R2", "src_on", int'(src_on), (m_st != 0 || m_pdn != 0) ? 1 : 0);
        chk("R3/R5/R7", "out_en", int'(out_en), en);
        chk("R4/R5", "out_sel", int'(out_sel), sel);
        chk("R6", "fb_div", int'(fb_div), fb_of(m_mult));
        chk("R6", "pre_div", int'(pre_div), pre_of(m_mult));
        chk("R7", "mult_ok", int'(mult_ok), ok_m);
        chk("R8/R9", "settled", int'(settled), (m_st != 0 && m_set == 0) ? 1 : 0);
        chk("R10", "glitch_free", int'(glitch_free), (m_st == 2 && m_gl == 0) ? 1 : 0);
        chk("R10", "phase_locked", int'(phase_locked), (m_st == 2 && m_ph == 0) ? 1 : 0);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        // R11: reset state
        run(4);
        chk("R11", "reset src_on", int'(src_on), 0);
        chk("R11", "reset state", int'(pwr_state), 0);
        rst_n = 1'b1;
        run(3);
        // R8: power-up into running, aligned clock, code 0
        pd_n = 1'b1;
        run(70);
        chk("R8", "settled after power-up", int'(settled), 1);
        // R9/R6: multiplier swaps, including an undefined code (R7)
        mult_sel = 3'd1; run(30);
        mult_sel = 3'd3; run(5);
        chk("R7", "undef mult out_en", int'(out_en), 0);
        mult_sel = 3'd5; run(30);
        mult_sel = 3'd2; run(3);
        mult_sel = 3'd4; run(28);
        mult_sel = 3'd6; run(28);
        // R10: halt and resume
        halt_n = 1'b0; run(5);
        chk("R3", "halt out_en", int'(out_en), 0);
        halt_n = 1'b1; run(25);
        // R10: interrupted resume window, and mult swap while halted (R9)
        halt_n = 1'b0; run(3);
        halt_n = 1'b1; run(2);
        halt_n = 1'b0; mult_sel = 3'd0; run(1);
        halt_n = 1'b1; run(30);
        // R4: mode change while powered is ignored
        mode_sel = 3'b100; run(4);
        chk("R4", "mode ignored while powered", int'(out_sel), 0);
        // R2: power-down delay, then each mode
        for (int k = 0; k < 7; k++) begin
            logic [2:0] mv;
            case (k)
                0: mv = 3'b100; 1: mv = 3'b110; 2: mv = 3'b010; 3: mv = 3'b011;
                4: mv = 3'b001; 5: mv = 3'b101; default: mv = 3'b111;
            endcase
            pd_n = 1'b0; mode_sel = 3'b000; run(13);
            mode_sel = mv; run(2);
            pd_n = 1'b1; halt_n = (k == 3) ? 1'b0 : 1'b1; run(4);
            halt_n = 1'b1; run(PWRUP + 2);
        end
        pd_n = 1'b0; run(2);
        mode_sel = 3'b000; pd_n = 1'b1; run(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule